// File: doc/BRIEF.md
# Snooping MESI Coherence Controller for a Set-Indexed Line Array

This block holds the coherence state of a small array of cache lines, one line per set, and moves each line through the four MESI states. Two kinds of events drive it. The local processor can ask to read, write or evict a line. The shared bus can report that another cache is reading or writing a line. For each event the controller picks the next state for the addressed line. It can also raise a bus request, ask for a writeback of dirty data to memory, or answer a snoop.

Line data, bus arbitration and memory are not part of this block. They appear only as request and done handshakes. Only one local request can be outstanding at a time. Snoops are handled in the same cycle they arrive and never stall. When a snoop and a local request address the same set in the same cycle, the snoop takes effect first and the local request waits one cycle. The state of the line named on `cpu_set` is always visible on `line_state`.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` is high, and no bus or writeback request is raised. Line states are encoded as Invalid=0, Shared=1, Exclusive=2, Modified=3. `cpu_op` is encoded as read=0, write=1, evict=2 and no-op=3.
- R2: A read to an Invalid line raises a bus read (`bus_req_cmd`=1). When `bus_done` is sampled, the line becomes Shared if `bus_shared_in` is high and Exclusive if it is low. `cpu_done` pulses the cycle after completion.
- R3: A write to an Invalid line raises a read-exclusive request (`bus_req_cmd`=2) and the line ends in Modified.
- R4: A write to an Exclusive line makes it Modified with no bus request, and `cpu_done` is high in the next cycle.
- R5: A write to a Shared line raises an upgrade request (`bus_req_cmd`=3) and the line ends in Modified. If a snooped write invalidates that line while the upgrade is still waiting, the pending command becomes read-exclusive (2).
- R6: Reads to Shared, Exclusive or Modified lines, writes to Modified lines, and no-ops all complete in one cycle without the bus. A read or no-op leaves the state unchanged.
- R7: A snooped write to a valid line makes it Invalid. `snoop_flush` is asserted in that cycle only if the line was Modified.
- R8: A snooped read to a Modified line asserts `snoop_flush` and moves the line to Shared. A snooped read to an Exclusive line moves it to Shared. Any snooped read hitting a valid line asserts `snoop_shared`.
- R9: A snoop to an Invalid line asserts neither `snoop_shared` nor `snoop_flush` and leaves the line Invalid.
- R10: Evicting a Modified line holds `wb_req_valid` with a stable `wb_req_set` until `wb_done`, then makes the line Invalid. Evicting a Shared or Exclusive line makes it Invalid in one cycle with no writeback.
- R11: When `snoop_valid` and `cpu_valid` address the same set in one cycle, `cpu_ready` is low. The local request is then handled on the line state the snoop left.
- R12: While a bus or writeback request is outstanding, `cpu_ready` is low. A raised bus request keeps `bus_req_valid` and `bus_req_set` stable until `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Local request present |
| cpu_op | input | 2 | Local operation (read, write, evict, no-op) |
| cpu_set | input | SET_W | Set addressed by the local request; also selects `line_state` |
| cpu_ready | output | 1 | Local request is accepted this cycle |
| cpu_done | output | 1 | One-cycle pulse when a local request completes |
| cpu_done_state | output | 2 | Final line state of the completed request |
| line_state | output | 2 | Current state of the line at `cpu_set` |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 1 read, 2 read-exclusive, 3 upgrade |
| bus_req_set | output | SET_W | Set of the bus transaction |
| bus_done | input | 1 | Bus transaction finished |
| bus_shared_in | input | 1 | Another cache holds the line, sampled with `bus_done` |
| wb_req_valid | output | 1 | Eviction writeback requested |
| wb_req_set | output | SET_W | Set being written back |
| wb_done | input | 1 | Writeback finished |
| snoop_valid | input | 1 | Snooped bus transaction present |
| snoop_write | input | 1 | Snoop is a write or ownership request (else a read) |
| snoop_set | input | SET_W | Set addressed by the snoop |
| snoop_shared | output | 1 | Snooped read hit a valid line |
| snoop_flush | output | 1 | Snoop hit a Modified line; dirty data must be supplied |

## Verification
Read misses are run with `bus_shared_in` low and then high. This separates the Exclusive fill from the Shared fill. Writes are applied to lines in every state. This shows which writes stay silent (Exclusive and Modified), which upgrade (Shared) and which fetch ownership (Invalid). One upgrade has its line invalidated by a snoop while it waits, which checks the switch to read-exclusive. Snoop reads and writes are aimed at Modified, Exclusive, Shared and Invalid lines so that the flush, shared and invalidate responses can be told apart. Finally, a local write to an Exclusive line and a snoop read to the same set arrive together. The snoop-first order shows up as an upgrade request, where the reverse order would give a silent write.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_E = 2'd2,
      ST_M = 2'd3
   } line_st_e;

   typedef enum logic [1:0] {
      OP_RD  = 2'd0,
      OP_WR  = 2'd1,
      OP_EV  = 2'd2,
      OP_NOP = 2'd3
   } cpu_op_e;

   typedef enum logic [1:0] {
      BC_NONE = 2'd0,
      BC_RD   = 2'd1,
      BC_RDX  = 2'd2,
      BC_UPG  = 2'd3
   } bus_cmd_e;

   typedef enum logic [1:0] {
      ACT_HIT = 2'd0,
      ACT_BUS = 2'd1,
      ACT_WB  = 2'd2
   } cpu_act_e;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_BUS  = 2'd1,
      FS_WB   = 2'd2
   } ctl_fsm_e;

   typedef struct packed {
      cpu_act_e act;
      line_st_e nxt;
      bus_cmd_e cmd;
   } cpu_dec_t;

endpackage

// File: rtl/mesi_cpu_decode.sv
module mesi_cpu_decode
   import mesi_pkg::*;
(
   input  cpu_op_e  op,
   input  line_st_e cur,
   output cpu_dec_t dec
);

   always_comb begin
      dec.act = ACT_HIT;
      dec.nxt = cur;
      dec.cmd = BC_NONE;
      unique case (op)
         OP_RD: begin
            if (cur == ST_I) begin
               dec.act = ACT_BUS;
               dec.cmd = BC_RD;
            end
         end
         OP_WR: begin
            unique case (cur)
               ST_I: begin
                  dec.act = ACT_BUS;
                  dec.cmd = BC_RDX;
               end
               ST_S: begin
                  dec.act = ACT_BUS;
                  dec.cmd = BC_UPG;
               end
               default: dec.nxt = ST_M;
            endcase
         end
         OP_EV: begin
            if (cur == ST_M) dec.act = ACT_WB;
            else             dec.nxt = ST_I;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
   import mesi_pkg::*;
(
   input  logic     valid,
   input  logic     write,
   input  line_st_e cur,
   output logic     upd,
   output line_st_e nxt,
   output logic     shared,
   output logic     flush
);

   logic hit;
   assign hit = valid && (cur != ST_I);

   always_comb begin
      upd    = 1'b0;
      nxt    = cur;
      shared = 1'b0;
      flush  = 1'b0;
      if (hit) begin
         upd   = 1'b1;
         flush = (cur == ST_M);
         if (write) begin
            nxt = ST_I;
         end else begin
            nxt    = ST_S;
            shared = 1'b1;
         end
      end
   end

endmodule

// File: rtl/mesi_line_array.sv
module mesi_line_array
   import mesi_pkg::*;
#(
   parameter  int NUM_SETS = 8,
   localparam int SET_W    = $clog2(NUM_SETS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SET_W-1:0]      rd_a_set,
   output line_st_e              rd_a_st,
   input  logic [SET_W-1:0]      rd_b_set,
   output line_st_e              rd_b_st,
   input  logic                  snp_we,
   input  logic [SET_W-1:0]      snp_set,
   input  line_st_e              snp_st,
   input  logic                  cpu_we,
   input  logic [SET_W-1:0]      cpu_set,
   input  line_st_e              cpu_st,
   output logic [2*NUM_SETS-1:0] st_flat
);

   line_st_e st_q [NUM_SETS];

   for (genvar g = 0; g < NUM_SETS; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[g] <= ST_I;
         end else if (cpu_we && (cpu_set == SET_W'(g))) begin
            st_q[g] <= cpu_st;
         end else if (snp_we && (snp_set == SET_W'(g))) begin
            st_q[g] <= snp_st;
         end
      end
      assign st_flat[2*g +: 2] = st_q[g];
   end

   assign rd_a_st = st_q[rd_a_set];
   assign rd_b_st = st_q[rd_b_set];

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter  int NUM_SETS = 8,
   localparam int SET_W    = $clog2(NUM_SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_valid,
   input  logic [1:0]       cpu_op,
   input  logic [SET_W-1:0] cpu_set,
   output logic             cpu_ready,
   output logic             cpu_done,
   output logic [1:0]       cpu_done_state,
   output logic [1:0]       line_state,
   output logic             bus_req_valid,
   output logic [1:0]       bus_req_cmd,
   output logic [SET_W-1:0] bus_req_set,
   input  logic             bus_done,
   input  logic             bus_shared_in,
   output logic             wb_req_valid,
   output logic [SET_W-1:0] wb_req_set,
   input  logic             wb_done,
   input  logic             snoop_valid,
   input  logic             snoop_write,
   input  logic [SET_W-1:0] snoop_set,
   output logic             snoop_shared,
   output logic             snoop_flush
);

   if (NUM_SETS < 2) begin : g_chk_min
      $error("mesi_line_ctrl: NUM_SETS must be at least 2");
   end
   if ((NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_chk_pow2
      $error("mesi_line_ctrl: NUM_SETS must be a power of two");
   end

   line_st_e             cpu_cur, snp_cur, snp_nxt, wr_st, fill_st;
   logic                 snp_upd;
   cpu_dec_t             dec;
   logic [2*NUM_SETS-1:0] st_flat;

   ctl_fsm_e             fsm_q;
   logic [SET_W-1:0]     pend_set_q;
   bus_cmd_e             pend_cmd_q;
   logic                 done_q;
   line_st_e             done_st_q;

   logic                 collide, accept, bus_fin, wb_fin, wr_en, lost_line;
   logic [SET_W-1:0]     wr_set;

   mesi_line_array #(.NUM_SETS(NUM_SETS)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_set (cpu_set),
      .rd_a_st  (cpu_cur),
      .rd_b_set (snoop_set),
      .rd_b_st  (snp_cur),
      .snp_we   (snp_upd),
      .snp_set  (snoop_set),
      .snp_st   (snp_nxt),
      .cpu_we   (wr_en),
      .cpu_set  (wr_set),
      .cpu_st   (wr_st),
      .st_flat  (st_flat)
   );

   mesi_snoop_resp u_snoop (
      .valid  (snoop_valid),
      .write  (snoop_write),
      .cur    (snp_cur),
      .upd    (snp_upd),
      .nxt    (snp_nxt),
      .shared (snoop_shared),
      .flush  (snoop_flush)
   );

   mesi_cpu_decode u_dec (
      .op  (cpu_op_e'(cpu_op)),
      .cur (cpu_cur),
      .dec (dec)
   );

   // A snoop to the requested set takes effect first; the local request waits.
   assign collide   = snoop_valid && (snoop_set == cpu_set);
   assign cpu_ready = (fsm_q == FS_IDLE) && !collide;
   assign accept    = cpu_valid && cpu_ready;

   assign bus_fin   = (fsm_q == FS_BUS) && bus_done;
   assign wb_fin    = (fsm_q == FS_WB)  && wb_done;
   assign fill_st   = (pend_cmd_q == BC_RD) ? (bus_shared_in ? ST_S : ST_E) : ST_M;

   assign wr_en     = (accept && (dec.act == ACT_HIT)) || bus_fin || wb_fin;
   assign wr_set    = accept ? cpu_set : pend_set_q;
   assign wr_st     = accept ? dec.nxt : (bus_fin ? fill_st : ST_I);

   // Pending upgrade whose Shared copy is being invalidated by another writer.
   assign lost_line = (fsm_q == FS_BUS) && (pend_cmd_q == BC_UPG) && snoop_valid
                      && snoop_write && (snoop_set == pend_set_q) && (snp_cur != ST_I);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm_q      <= FS_IDLE;
         pend_set_q <= '0;
         pend_cmd_q <= BC_NONE;
         done_q     <= 1'b0;
         done_st_q  <= ST_I;
      end else begin
         done_q <= 1'b0;
         unique case (fsm_q)
            FS_IDLE: begin
               if (accept) begin
                  pend_set_q <= cpu_set;
                  unique case (dec.act)
                     ACT_BUS: begin
                        fsm_q      <= FS_BUS;
                        pend_cmd_q <= dec.cmd;
                     end
                     ACT_WB: fsm_q <= FS_WB;
                     default: begin
                        done_q    <= 1'b1;
                        done_st_q <= dec.nxt;
                     end
                  endcase
               end
            end
            FS_BUS: begin
               if (bus_fin) begin
                  fsm_q      <= FS_IDLE;
                  pend_cmd_q <= BC_NONE;
                  done_q     <= 1'b1;
                  done_st_q  <= fill_st;
               end else if (lost_line) begin
                  pend_cmd_q <= BC_RDX;
               end
            end
            FS_WB: begin
               if (wb_fin) begin
                  fsm_q     <= FS_IDLE;
                  done_q    <= 1'b1;
                  done_st_q <= ST_I;
               end
            end
            default: fsm_q <= FS_IDLE;
         endcase
      end
   end

   assign cpu_done       = done_q;
   assign cpu_done_state = done_st_q;
   assign line_state     = cpu_cur;
   assign bus_req_valid  = (fsm_q == FS_BUS);
   assign bus_req_cmd    = bus_req_valid ? pend_cmd_q : BC_NONE;
   assign bus_req_set    = pend_set_q;
   assign wb_req_valid   = (fsm_q == FS_WB);
   assign wb_req_set     = pend_set_q;

endmodule

// File: rtl/mesi_ctrl_checker.sv
module mesi_ctrl_checker #(
   parameter  int NUM_SETS = 8,
   localparam int SET_W    = $clog2(NUM_SETS)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cpu_valid,
   input logic [1:0]            cpu_op,
   input logic [SET_W-1:0]      cpu_set,
   input logic                  cpu_ready,
   input logic                  bus_req_valid,
   input logic [SET_W-1:0]      bus_req_set,
   input logic                  bus_done,
   input logic                  wb_req_valid,
   input logic [SET_W-1:0]      wb_req_set,
   input logic                  wb_done,
   input logic                  snoop_valid,
   input logic                  snoop_write,
   input logic [SET_W-1:0]      snoop_set,
   input logic                  snoop_shared,
   input logic                  snoop_flush,
   input logic [2*NUM_SETS-1:0] line_flat
);

   function automatic logic [1:0] st_at(input logic [2*NUM_SETS-1:0] f,
                                        input logic [SET_W-1:0] s);
      return f[2*s +: 2];
   endfunction

   logic fill_here;
   assign fill_here = bus_req_valid && bus_done && (bus_req_set == snoop_set);

   assert_excl_write_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_ready && cpu_op == 2'd1 && st_at(line_flat, cpu_set) == 2'd2)
      |=> (!bus_req_valid && st_at(line_flat, $past(cpu_set)) == 2'd3));

   assert_snoop_write_inval_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_valid && snoop_write && !fill_here)
      |=> (st_at(line_flat, $past(snoop_set)) == 2'd0));

   assert_snoop_read_demote_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_valid && !snoop_write && !fill_here && st_at(line_flat, snoop_set) >= 2'd2)
      |=> (st_at(line_flat, $past(snoop_set)) == 2'd1));

   assert_resp_needs_snoop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_flush || snoop_shared) |-> snoop_valid);

   assert_collide_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_valid && cpu_valid && snoop_set == cpu_set) |-> !cpu_ready);

   assert_bus_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && !bus_done) |=> (bus_req_valid && $stable(bus_req_set)));

   assert_wb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_req_valid && !wb_done) |=> (wb_req_valid && $stable(wb_req_set)));

   assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid || wb_req_valid) |-> (!cpu_ready && !(bus_req_valid && wb_req_valid)));

endmodule

bind mesi_line_ctrl mesi_ctrl_checker #(.NUM_SETS(NUM_SETS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_valid     (cpu_valid),
   .cpu_op        (cpu_op),
   .cpu_set       (cpu_set),
   .cpu_ready     (cpu_ready),
   .bus_req_valid (bus_req_valid),
   .bus_req_set   (bus_req_set),
   .bus_done      (bus_done),
   .wb_req_valid  (wb_req_valid),
   .wb_req_set    (wb_req_set),
   .wb_done       (wb_done),
   .snoop_valid   (snoop_valid),
   .snoop_write   (snoop_write),
   .snoop_set     (snoop_set),
   .snoop_shared  (snoop_shared),
   .snoop_flush   (snoop_flush),
   .line_flat     (st_flat)
);

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;

   localparam int NSETS = 8;
   localparam int SW    = $clog2(NSETS);
   localparam int S_I = 0, S_S = 1, S_E = 2, S_M = 3;
   localparam int OPR = 0, OPW = 1, OPE = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_valid = 1'b0;
   logic [1:0]    cpu_op = 2'd0;
   logic [SW-1:0] cpu_set = '0;
   logic          cpu_ready, cpu_done;
   logic [1:0]    cpu_done_state, line_state;
   logic          bus_req_valid;
   logic [1:0]    bus_req_cmd;
   logic [SW-1:0] bus_req_set;
   logic          bus_done = 1'b0, bus_shared_in = 1'b0;
   logic          wb_req_valid;
   logic [SW-1:0] wb_req_set;
   logic          wb_done = 1'b0;
   logic          snoop_valid = 1'b0, snoop_write = 1'b0;
   logic [SW-1:0] snoop_set = '0;
   logic          snoop_shared, snoop_flush;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   mesi_line_ctrl #(.NUM_SETS(NSETS)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_set(cpu_set),
      .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_done_state(cpu_done_state),
      .line_state(line_state),
      .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_set(bus_req_set),
      .bus_done(bus_done), .bus_shared_in(bus_shared_in),
      .wb_req_valid(wb_req_valid), .wb_req_set(wb_req_set), .wb_done(wb_done),
      .snoop_valid(snoop_valid), .snoop_write(snoop_write), .snoop_set(snoop_set),
      .snoop_shared(snoop_shared), .snoop_flush(snoop_flush)
   );

   task automatic check(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
      end
   endtask

   task automatic peek(input int set, input int exp, input string req);
      cpu_set = SW'(set);
      #1;
      check(req, "line_state", int'(line_state), exp);
   endtask

   // One-cycle local request expected to finish without the bus.
   task automatic do_hit(input int op, input int set, input int exp, input string req);
      cpu_op = 2'(op); cpu_set = SW'(set); cpu_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      cpu_valid = 1'b0;
      check(req, "cpu_done", int'(cpu_done), 1);
      check(req, "done_state", int'(cpu_done_state), exp);
      check(req, "no bus request", int'(bus_req_valid), 0);
      peek(set, exp, req);
   endtask

   // Local request expected to raise a bus command, completed one cycle later.
   task automatic do_miss(input int op, input int set, input int cmd, input logic shr,
                          input int exp, input string req);
      cpu_op = 2'(op); cpu_set = SW'(set); cpu_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      cpu_valid = 1'b0;
      check(req, "bus_req_valid", int'(bus_req_valid), 1);
      check(req, "bus_req_cmd", int'(bus_req_cmd), cmd);
      check(req, "bus_req_set", int'(bus_req_set), set);
      bus_done = 1'b1; bus_shared_in = shr;
      @(posedge clk); @(negedge clk);
      bus_done = 1'b0; bus_shared_in = 1'b0;
      check(req, "cpu_done", int'(cpu_done), 1);
      check(req, "done_state", int'(cpu_done_state), exp);
      peek(set, exp, req);
   endtask

   task automatic do_snoop(input logic wr, input int set, input int exp_shr, input int exp_fl,
                           input int exp_st, input string req);
      snoop_valid = 1'b1; snoop_write = wr; snoop_set = SW'(set);
      #1;
      check(req, "snoop_shared", int'(snoop_shared), exp_shr);
      check(req, "snoop_flush", int'(snoop_flush), exp_fl);
      @(posedge clk); @(negedge clk);
      snoop_valid = 1'b0; snoop_write = 1'b0;
      peek(set, exp_st, req);
   endtask

   task automatic t_reset();
      for (int s = 0; s < NSETS; s++) peek(s, S_I, "R1");
      check("R1", "cpu_ready", int'(cpu_ready), 1);
      check("R1", "bus_req_valid", int'(bus_req_valid), 0);
      check("R1", "wb_req_valid", int'(wb_req_valid), 0);
   endtask

   task automatic t_read_miss();
      do_miss(OPR, 0, 1, 1'b0, S_E, "R2");
      do_miss(OPR, 1, 1, 1'b1, S_S, "R2");
   endtask

   task automatic t_hits();
      do_hit(OPR, 0, S_E, "R6");
      do_hit(OPR, 1, S_S, "R6");
      do_hit(3,   1, S_S, "R6");
   endtask

   task automatic t_excl_write();
      do_hit(OPW, 0, S_M, "R4");
      do_hit(OPW, 0, S_M, "R6");
      do_hit(OPR, 0, S_M, "R6");
   endtask

   task automatic t_write_miss();
      cpu_op = 2'(OPW); cpu_set = SW'(3); cpu_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      cpu_valid = 1'b0;
      check("R3", "bus_req_cmd", int'(bus_req_cmd), 2);
      @(negedge clk);
      check("R12", "request held", int'(bus_req_valid), 1);
      check("R12", "set held", int'(bus_req_set), 3);
      check("R12", "cpu_ready low", int'(cpu_ready), 0);
      bus_done = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_done = 1'b0;
      check("R3", "done_state", int'(cpu_done_state), S_M);
      peek(3, S_M, "R3");
   endtask

   task automatic t_upgrade();
      do_miss(OPW, 1, 3, 1'b0, S_M, "R5");
   endtask

   task automatic t_upgrade_lost();
      do_miss(OPR, 4, 1, 1'b1, S_S, "R5");
      cpu_op = 2'(OPW); cpu_set = SW'(4); cpu_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      cpu_valid = 1'b0;
      check("R5", "upgrade cmd", int'(bus_req_cmd), 3);
      snoop_valid = 1'b1; snoop_write = 1'b1; snoop_set = SW'(4);
      @(posedge clk); @(negedge clk);
      snoop_valid = 1'b0; snoop_write = 1'b0;
      check("R5", "fallback cmd", int'(bus_req_cmd), 2);
      bus_done = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_done = 1'b0;
      check("R5", "cpu_done", int'(cpu_done), 1);
      peek(4, S_M, "R5");
   endtask

   task automatic t_snoop_read();
      do_snoop(1'b0, 0, 1, 1, S_S, "R8");
      do_snoop(1'b0, 5, 0, 0, S_I, "R9");
      do_miss(OPR, 6, 1, 1'b0, S_E, "R2");
      do_snoop(1'b0, 6, 1, 0, S_S, "R8");
      do_snoop(1'b0, 6, 1, 0, S_S, "R8");
   endtask

   task automatic t_snoop_write();
      do_snoop(1'b1, 3, 0, 1, S_I, "R7");
      do_snoop(1'b1, 6, 0, 0, S_I, "R7");
      do_snoop(1'b1, 5, 0, 0, S_I, "R9");
   endtask

   task automatic t_collide();
      do_miss(OPR, 2, 1, 1'b0, S_E, "R11");
      cpu_op = 2'(OPW); cpu_set = SW'(2); cpu_valid = 1'b1;
      snoop_valid = 1'b1; snoop_write = 1'b0; snoop_set = SW'(2);
      #1;
      check("R11", "cpu_ready low", int'(cpu_ready), 0);
      check("R11", "snoop_shared", int'(snoop_shared), 1);
      @(posedge clk); @(negedge clk);
      snoop_valid = 1'b0;
      #1;
      check("R11", "state after snoop", int'(line_state), S_S);
      check("R11", "cpu_ready", int'(cpu_ready), 1);
      @(posedge clk); @(negedge clk);
      cpu_valid = 1'b0;
      check("R11", "upgrade issued", int'(bus_req_cmd), 3);
      bus_done = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_done = 1'b0;
      peek(2, S_M, "R11");
   endtask

   task automatic t_evict();
      cpu_op = 2'(OPE); cpu_set = SW'(1); cpu_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      cpu_valid = 1'b0;
      check("R10", "wb_req_valid", int'(wb_req_valid), 1);
      check("R10", "wb_req_set", int'(wb_req_set), 1);
      check("R10", "no bus request", int'(bus_req_valid), 0);
      @(negedge clk);
      check("R10", "wb held", int'(wb_req_valid), 1);
      check("R12", "cpu_ready low", int'(cpu_ready), 0);
      wb_done = 1'b1;
      @(posedge clk); @(negedge clk);
      wb_done = 1'b0;
      check("R10", "cpu_done", int'(cpu_done), 1);
      check("R10", "wb released", int'(wb_req_valid), 0);
      peek(1, S_I, "R10");
      cpu_op = 2'(OPE); cpu_set = SW'(0); cpu_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      cpu_valid = 1'b0;
      check("R10", "clean evict done", int'(cpu_done), 1);
      check("R10", "clean evict no wb", int'(wb_req_valid), 0);
      peek(0, S_I, "R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_miss();
      t_hits();
      t_excl_write();
      t_write_miss();
      t_upgrade();
      t_upgrade_lost();
      t_snoop_read();
      t_snoop_write();
      t_collide();
      t_evict();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule